// File: doc/BRIEF.md
# Dual-Mode Section Address Filter Bank

This block sits after section decapsulation in a satellite receiver and decides which multiprotocol-encapsulated sections are handed on to an Ethernet framer. It holds eight filter slots. Each slot carries an enable, a 13-bit transport PID and a 48-bit destination MAC address. A section is accepted only if one slot matches on both fields. The PID comparison picks the candidate slots first. The MAC comparison then narrows them, and it only looks at slots whose PID already agreed. An accepted section is passed on beat by beat, together with the number of the slot that caught it and the stream it came from. A section that no slot catches is consumed in full and counted.

A mode input chooses how the slots map onto the input streams. In single mode, stream A is the only source and every slot applies to it. In dual mode, stream A is judged against the lower half of the slots and stream B against the upper half. The two streams take turns, one whole section at a time, on the single output port. Slot contents are written through a small write-only port. A write never alters the routing of a section that has already been decided.

Every section carries its PID and MAC on sideband inputs that stay constant for all of its beats. The first beat a stream presents while the block is idle is taken as the start of a new section. The block spends one cycle on the decision before the first beat moves.

Top module: `section_filter_bank`

## Requirements
- R1: There are eight slots, each loaded with enable, PID and MAC through the configuration port. A slot whose enable is 0 never accepts a section.
- R2: A section is accepted only when a single slot has both the same PID and the same MAC. A PID held in one slot and a MAC held in another slot give no match.
- R3: When several slots accept a section, the lowest-numbered one wins, and its number (0 to 7) appears on `m_slot` for every beat of that section.
- R4: When `dual_mode` is 0, stream A is compared against all eight slots. Stream B is never served, so `b_ready` stays 0 and nothing from B reaches the output.
- R5: When `dual_mode` is 1, stream A is compared only against slots 0–3 and stream B only against slots 4–7.
- R6: The beats of an accepted section leave in order with their data and last flag unchanged. `m_src` is 0 for stream A and 1 for stream B.
- R7: A section with no matching slot is accepted and discarded up to and including its last beat. Nothing of it appears on the output, and `drop_cnt` rises by exactly one for that section.
- R8: A configuration write made while a section is in flight does not change that section's outcome or `m_slot`. It applies from the next section decided.
- R9: In dual mode, when both streams have a section waiting, the stream that was not served last goes next. After reset, stream A has priority.
- R10: The output follows valid/ready. While `m_valid` is high and `m_ready` is low, the beat and its slot stay unchanged. At most one input stream is granted ready in any cycle.
- R11: After reset, `m_valid` is 0, `drop_cnt` is 0 and every slot is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 0: stream A uses all slots; 1: A uses slots 0–3 and B uses slots 4–7 |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | 3 | Slot number to write |
| cfg_en | input | 1 | Enable value for the slot |
| cfg_pid | input | 13 | PID value for the slot |
| cfg_mac | input | 48 | Destination MAC value for the slot |
| a_valid | input | 1 | Stream A beat valid |
| a_ready | output | 1 | Stream A beat taken |
| a_pid | input | 13 | Stream A section PID, constant across the section |
| a_mac | input | 48 | Stream A section destination MAC, constant across the section |
| a_data | input | 32 | Stream A payload beat |
| a_last | input | 1 | Stream A final beat of the section |
| b_valid | input | 1 | Stream B beat valid |
| b_ready | output | 1 | Stream B beat taken |
| b_pid | input | 13 | Stream B section PID |
| b_mac | input | 48 | Stream B section destination MAC |
| b_data | input | 32 | Stream B payload beat |
| b_last | input | 1 | Stream B final beat of the section |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream framer takes the beat |
| m_data | output | 32 | Output payload beat |
| m_last | output | 1 | Final beat of the forwarded section |
| m_slot | output | 3 | Number of the slot that accepted the section |
| m_src | output | 1 | Source stream of the section (0 = A, 1 = B) |
| drop_cnt | output | 16 | Count of discarded sections, wrapping |

## Verification
The assertions rely on a few properties of the inputs. A source keeps `valid`, its data, last flag and header sideband steady until the beat is taken. PID and MAC do not change inside a section. `dual_mode` changes only while no section is in flight. The stimulus drives every input a fixed time after the rising edge and reads ready at the falling edge. Each source holds its beat until that read shows the beat will be taken. The mode is switched only between tests, once the previous sections have fully drained.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam int PID_W = 13;
    localparam int MAC_W = 48;

    typedef struct packed {
        logic             en;
        logic [PID_W-1:0] pid;
        logic [MAC_W-1:0] mac;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        SFB_IDLE = 2'd0,
        SFB_FWD  = 2'd1,
        SFB_DROP = 2'd2
    } sfb_state_e;

endpackage

// File: rtl/sfb_slot_table.sv
module sfb_slot_table
    import sfb_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_en_i,
    input  logic [PID_W-1:0] wr_pid_i,
    input  logic [MAC_W-1:0] wr_mac_i,
    output slot_cfg_t        slots_o [N_SLOTS]
);

    slot_cfg_t tbl_d [N_SLOTS];
    slot_cfg_t tbl_q [N_SLOTS];

    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        if (wr_i) begin
            tbl_d[wr_idx_i] = '{en: wr_en_i, pid: wr_pid_i, mac: wr_mac_i};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_SLOTS; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_out
        assign slots_o[g] = tbl_q[g];
    end

    // R11
    slots_off_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !tbl_q[0].en && !tbl_q[N_SLOTS-1].en);

endmodule

// File: rtl/sfb_matcher.sv
module sfb_matcher
    import sfb_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = 3
) (
    input  slot_cfg_t        slots_i [N_SLOTS],
    input  logic [PID_W-1:0] pid_i,
    input  logic [MAC_W-1:0] mac_i,
    input  logic [IDX_W-1:0] lo_i,
    input  logic [IDX_W-1:0] hi_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);

    logic [N_SLOTS-1:0] pid_hit;
    logic [N_SLOTS-1:0] mac_hit;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic in_win;
        assign in_win     = (IDX_W'(g) >= lo_i) && (IDX_W'(g) <= hi_i);
        // first stage: transport PID within the stream's window
        assign pid_hit[g] = slots_i[g].en && in_win && (slots_i[g].pid == pid_i);
        // second stage: MAC only on slots that passed the PID stage
        assign mac_hit[g] = pid_hit[g] && (slots_i[g].mac == mac_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (mac_hit[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign hit_o = |mac_hit;

endmodule

// File: rtl/sfb_rr_pick.sv
module sfb_rr_pick (
    input  logic dual_i,
    input  logic a_req_i,
    input  logic b_req_i,
    input  logic last_b_i,
    output logic go_o,
    output logic pick_b_o
);

    logic b_eff;

    assign b_eff    = dual_i && b_req_i;
    assign go_o     = a_req_i || b_eff;
    assign pick_b_o = b_eff && (!a_req_i || !last_b_i);

endmodule

// File: rtl/section_filter_bank.sv
module section_filter_bank
    import sfb_pkg::*;
#(
    parameter  int N_SLOTS = 8,
    parameter  int DATA_W  = 32,
    parameter  int CNT_W   = 16,
    localparam int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_mode,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [PID_W-1:0]  cfg_pid,
    input  logic [MAC_W-1:0]  cfg_mac,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [PID_W-1:0]  a_pid,
    input  logic [MAC_W-1:0]  a_mac,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_last,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [PID_W-1:0]  b_pid,
    input  logic [MAC_W-1:0]  b_mac,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    output logic [IDX_W-1:0]  m_slot,
    output logic              m_src,
    output logic [CNT_W-1:0]  drop_cnt
);

    localparam int HALF = N_SLOTS / 2;

    typedef struct packed {
        sfb_state_e       st;
        logic             own_b;
        logic [IDX_W-1:0] slot;
        logic             last_b;
        logic [CNT_W-1:0] drops;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    slot_cfg_t        slots [N_SLOTS];
    logic             go;
    logic             pick_b;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [PID_W-1:0] sel_pid;
    logic [MAC_W-1:0] sel_mac;
    logic [IDX_W-1:0] win_lo;
    logic [IDX_W-1:0] win_hi;
    logic             own_valid;
    logic             own_last;
    logic             in_fwd;
    logic             in_drop;

    sfb_slot_table #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_we),
        .wr_idx_i (cfg_idx),
        .wr_en_i  (cfg_en),
        .wr_pid_i (cfg_pid),
        .wr_mac_i (cfg_mac),
        .slots_o  (slots)
    );

    sfb_rr_pick pick_i (
        .dual_i   (dual_mode),
        .a_req_i  (a_valid),
        .b_req_i  (b_valid),
        .last_b_i (ctl_q.last_b),
        .go_o     (go),
        .pick_b_o (pick_b)
    );

    assign sel_pid = pick_b ? b_pid : a_pid;
    assign sel_mac = pick_b ? b_mac : a_mac;

    always_comb begin
        if (!dual_mode) begin
            win_lo = '0;
            win_hi = IDX_W'(N_SLOTS - 1);
        end else if (pick_b) begin
            win_lo = IDX_W'(HALF);
            win_hi = IDX_W'(N_SLOTS - 1);
        end else begin
            win_lo = '0;
            win_hi = IDX_W'(HALF - 1);
        end
    end

    sfb_matcher #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) match_i (
        .slots_i (slots),
        .pid_i   (sel_pid),
        .mac_i   (sel_mac),
        .lo_i    (win_lo),
        .hi_i    (win_hi),
        .hit_o   (hit),
        .idx_o   (hit_idx)
    );

    assign own_valid = ctl_q.own_b ? b_valid : a_valid;
    assign own_last  = ctl_q.own_b ? b_last  : a_last;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            SFB_IDLE: begin
                if (go) begin
                    ctl_d.own_b  = pick_b;
                    ctl_d.last_b = pick_b;
                    if (hit) begin
                        ctl_d.st   = SFB_FWD;
                        ctl_d.slot = hit_idx;
                    end else begin
                        ctl_d.st    = SFB_DROP;
                        ctl_d.drops = ctl_q.drops + CNT_W'(1);
                    end
                end
            end
            SFB_FWD: begin
                if (own_valid && m_ready && own_last) begin
                    ctl_d.st = SFB_IDLE;
                end
            end
            SFB_DROP: begin
                if (own_valid && own_last) begin
                    ctl_d.st = SFB_IDLE;
                end
            end
            default: ctl_d.st = SFB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.st     <= SFB_IDLE;
            ctl_q.last_b <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_fwd   = (ctl_q.st == SFB_FWD);
    assign in_drop  = (ctl_q.st == SFB_DROP);
    assign m_valid  = in_fwd && own_valid;
    assign m_data   = ctl_q.own_b ? b_data : a_data;
    assign m_last   = own_last;
    assign m_slot   = ctl_q.slot;
    assign m_src    = ctl_q.own_b;
    assign drop_cnt = ctl_q.drops;
    assign a_ready  = !ctl_q.own_b && (in_fwd ? m_ready : in_drop);
    assign b_ready  =  ctl_q.own_b && (in_fwd ? m_ready : in_drop);

    // R2
    hit_both_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == SFB_IDLE && go && hit) |->
            slots[hit_idx].en && slots[hit_idx].pid == sel_pid && slots[hit_idx].mac == sel_mac);

    // R5
    b_upper_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == SFB_IDLE && dual_mode && go && pick_b && hit) |-> hit_idx >= IDX_W'(HALF));

    // R4
    single_b_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == SFB_IDLE && !dual_mode) |=> !b_ready);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> m_valid && $stable(m_data) && $stable(m_slot) && $stable(m_src));

    // R10
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_ready, b_ready}));

    // R7
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + CNT_W'(1)));

endmodule

// File: tb/section_filter_bank_tb_top.sv
`timescale 1ns/1ps
module section_filter_bank_tb_top;

    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dual_mode = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic          cfg_en = 1'b0;
    logic [12:0]   cfg_pid = '0;
    logic [47:0]   cfg_mac = '0;
    logic          a_valid = 1'b0, b_valid = 1'b0;
    logic          a_ready, b_ready;
    logic [12:0]   a_pid = '0, b_pid = '0;
    logic [47:0]   a_mac = '0, b_mac = '0;
    logic [DW-1:0] a_data = '0, b_data = '0;
    logic          a_last = 1'b0, b_last = 1'b0;
    logic          m_valid, m_last, m_src;
    logic          m_ready = 1'b1;
    logic [DW-1:0] m_data;
    logic [2:0]    m_slot;
    logic [CW-1:0] drop_cnt;

    always #4 clk = ~clk;

    section_filter_bank dut_i (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_pid(cfg_pid), .cfg_mac(cfg_mac),
        .a_valid(a_valid), .a_ready(a_ready), .a_pid(a_pid), .a_mac(a_mac), .a_data(a_data), .a_last(a_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_pid(b_pid), .b_mac(b_mac), .b_data(b_data), .b_last(b_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .m_slot(m_slot), .m_src(m_src), .drop_cnt(drop_cnt)
    );

    int checks = 0;
    int errors = 0;
    int exp_drops = 0;
    int stall_bad = 0;

    typedef struct {
        logic [DW-1:0] d;
        logic          last;
        logic [2:0]    slot;
        logic          src;
    } beat_t;

    beat_t outq[$];

    logic          pv_stall = 1'b0;
    logic [DW-1:0] pv_data = '0;
    logic [2:0]    pv_slot = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (m_valid && m_ready) outq.push_back('{m_data, m_last, m_slot, m_src});
            if (pv_stall && (!m_valid || m_data != pv_data || m_slot != pv_slot)) stall_bad++;
            pv_stall = m_valid && !m_ready;
            pv_data  = m_data;
            pv_slot  = m_slot;
        end else begin
            pv_stall = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; a_valid = 1'b0; b_valid = 1'b0; m_ready = 1'b1; cfg_we = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        outq.delete();
        exp_drops = 0;
    endtask

    task automatic cfg_write(input int idx, input bit en, input logic [12:0] pid, input logic [47:0] mac);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_en = en; cfg_pid = pid; cfg_mac = mac;
        @(posedge clk);
        #2 cfg_we = 1'b0;
    endtask

    task automatic clear_slots();
        for (int i = 0; i < 8; i++) cfg_write(i, 1'b0, '0, '0);
    endtask

    task automatic send(input bit s, input logic [12:0] pid, input logic [47:0] mac,
                        input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            if (s) begin
                b_valid = 1'b1; b_pid = pid; b_mac = mac; b_data = base + DW'(i); b_last = (i == n - 1);
            end else begin
                a_valid = 1'b1; a_pid = pid; a_mac = mac; a_data = base + DW'(i); a_last = (i == n - 1);
            end
            forever begin
                @(negedge clk);
                if (s ? b_ready : a_ready) break;
            end
            @(posedge clk);
            #2;
        end
        if (s) b_valid = 1'b0; else a_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #2;
    endtask

    task automatic expect_section(input string req, input bit src, input int slot,
                                  input logic [DW-1:0] base, input int n);
        bit ok = 1'b1;
        longint act = 0, exp = 0;
        string what = "section";
        beat_t b;
        for (int i = 0; i < n; i++) begin
            if (outq.size() == 0) begin ok = 0; what = "beat count"; act = i; exp = n; break; end
            b = outq.pop_front();
            if (b.d != base + DW'(i)) begin ok = 0; what = "data"; act = b.d; exp = base + DW'(i); break; end
            if (b.slot != 3'(slot)) begin ok = 0; what = "slot"; act = b.slot; exp = slot; break; end
            if (b.src != src) begin ok = 0; what = "src"; act = b.src; exp = src; break; end
            if (b.last != (i == n - 1)) begin ok = 0; what = "last"; act = b.last; exp = (i == n - 1); break; end
        end
        chk(ok, req, what, act, exp);
    endtask

    task automatic expect_empty(input string req);
        chk(outq.size() == 0, req, "unexpected output beats", outq.size(), 0);
    endtask

    task automatic expect_drops(input string req);
        chk(drop_cnt == CW'(exp_drops), req, "drop_cnt", drop_cnt, exp_drops);
    endtask

    // R11
    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(m_valid == 1'b0, "R11", "m_valid", m_valid, 0);
        chk(drop_cnt == '0, "R11", "drop_cnt", drop_cnt, 0);
        @(posedge clk); #2;
        send(0, 13'h010, 48'h0, 2, 32'h100);
        exp_drops++;
        settle();
        expect_empty("R11");
        expect_drops("R11");
    endtask

    // R1 R2 R6
    task automatic t_basic();
        cfg_write(2, 1'b1, 13'h0A5, 48'h0011_2233_4455);
        send(0, 13'h0A5, 48'h0011_2233_4455, 4, 32'hA000);
        settle();
        expect_section("R6", 0, 2, 32'hA000, 4);
        send(0, 13'h0A5, 48'h0011_2233_4455, 1, 32'hA100);
        settle();
        expect_section("R1", 0, 2, 32'hA100, 1);
        cfg_write(3, 1'b1, 13'h0B0, 48'hAAAA_0000_0001);
        cfg_write(5, 1'b1, 13'h0B1, 48'hAAAA_0000_0002);
        send(0, 13'h0B0, 48'hAAAA_0000_0002, 2, 32'hA200);
        exp_drops++;
        settle();
        expect_empty("R2");
        expect_drops("R2");
    endtask

    // R3 R1
    task automatic t_prio();
        clear_slots();
        cfg_write(6, 1'b1, 13'h111, 48'hBEEF_0000_0006);
        cfg_write(1, 1'b1, 13'h111, 48'hBEEF_0000_0006);
        send(0, 13'h111, 48'hBEEF_0000_0006, 3, 32'hB000);
        settle();
        expect_section("R3", 0, 1, 32'hB000, 3);
        cfg_write(1, 1'b0, 13'h111, 48'hBEEF_0000_0006);
        send(0, 13'h111, 48'hBEEF_0000_0006, 2, 32'hB100);
        settle();
        expect_section("R1", 0, 6, 32'hB100, 2);
    endtask

    // R4
    task automatic t_single_b();
        int seen = 0;
        dual_mode = 1'b0;
        clear_slots();
        cfg_write(6, 1'b1, 13'h066, 48'h6666_6666_6666);
        b_valid = 1'b1; b_pid = 13'h066; b_mac = 48'h6666_6666_6666; b_data = 32'hC000; b_last = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (b_ready) seen++;
        end
        @(posedge clk); #2 b_valid = 1'b0;
        chk(seen == 0, "R4", "b_ready cycles", seen, 0);
        expect_empty("R4");
        send(0, 13'h066, 48'h6666_6666_6666, 2, 32'hC100);
        settle();
        expect_section("R4", 0, 6, 32'hC100, 2);
    endtask

    // R5
    task automatic t_dual();
        dual_mode = 1'b1;
        clear_slots();
        cfg_write(6, 1'b1, 13'h066, 48'h6666_6666_6666);
        cfg_write(1, 1'b1, 13'h011, 48'h1111_1111_1111);
        send(0, 13'h066, 48'h6666_6666_6666, 2, 32'hD000);
        exp_drops++;
        settle();
        expect_empty("R5");
        expect_drops("R5");
        send(1, 13'h066, 48'h6666_6666_6666, 3, 32'hD100);
        settle();
        expect_section("R5", 1, 6, 32'hD100, 3);
        send(1, 13'h011, 48'h1111_1111_1111, 2, 32'hD200);
        exp_drops++;
        settle();
        expect_empty("R5");
        expect_drops("R5");
        send(0, 13'h011, 48'h1111_1111_1111, 2, 32'hD300);
        settle();
        expect_section("R5", 0, 1, 32'hD300, 2);
    endtask

    // R9
    task automatic t_rr();
        do_reset();
        dual_mode = 1'b1;
        cfg_write(0, 1'b1, 13'h100, 48'h0A0A_0A0A_0A0A);
        cfg_write(4, 1'b1, 13'h200, 48'h0B0B_0B0B_0B0B);
        fork
            begin
                send(0, 13'h100, 48'h0A0A_0A0A_0A0A, 2, 32'hE000);
                send(0, 13'h100, 48'h0A0A_0A0A_0A0A, 2, 32'hE100);
            end
            begin
                send(1, 13'h200, 48'h0B0B_0B0B_0B0B, 3, 32'hF000);
                send(1, 13'h200, 48'h0B0B_0B0B_0B0B, 3, 32'hF100);
            end
        join
        settle();
        expect_section("R9", 0, 0, 32'hE000, 2);
        expect_section("R9", 1, 4, 32'hF000, 3);
        expect_section("R9", 0, 0, 32'hE100, 2);
        expect_section("R9", 1, 4, 32'hF100, 3);
    endtask

    // R8
    task automatic t_cfg_mid();
        dual_mode = 1'b0;
        clear_slots();
        cfg_write(0, 1'b1, 13'h123, 48'h1234_5678_9ABC);
        m_ready = 1'b0;
        fork
            send(0, 13'h123, 48'h1234_5678_9ABC, 5, 32'h5000);
            begin
                repeat (3) @(posedge clk);
                #2;
                cfg_write(0, 1'b0, 13'h123, 48'h1234_5678_9ABC);
                m_ready = 1'b1;
            end
        join
        settle();
        expect_section("R8", 0, 0, 32'h5000, 5);
        send(0, 13'h123, 48'h1234_5678_9ABC, 2, 32'h5100);
        exp_drops++;
        settle();
        expect_empty("R8");
        expect_drops("R8");
    endtask

    // R10
    task automatic t_backpressure();
        stall_bad = 0;
        clear_slots();
        cfg_write(7, 1'b1, 13'h077, 48'h7777_0000_7777);
        fork
            begin
                send(0, 13'h077, 48'h7777_0000_7777, 6, 32'h7000);
                send(0, 13'h077, 48'h7777_0000_7777, 3, 32'h7100);
            end
            begin
                for (int i = 0; i < 30; i++) begin
                    m_ready = (i % 3) != 0;
                    @(posedge clk);
                    #2;
                end
                m_ready = 1'b1;
            end
        join
        settle();
        expect_section("R10", 0, 7, 32'h7000, 6);
        expect_section("R10", 0, 7, 32'h7100, 3);
        chk(stall_bad == 0, "R10", "beat changed under stall", stall_bad, 0);
    endtask

    // R7
    task automatic t_drop_long();
        cfg_write(2, 1'b1, 13'h022, 48'h2222_2222_2222);
        send(0, 13'h033, 48'h2222_2222_2222, 5, 32'h9000);
        exp_drops++;
        settle();
        expect_empty("R7");
        expect_drops("R7");
        send(0, 13'h022, 48'h2222_2222_2222, 2, 32'h9100);
        settle();
        expect_section("R7", 0, 2, 32'h9100, 2);
        expect_drops("R7");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_prio();
        t_single_b();
        t_dual();
        t_rr();
        t_cfg_mid();
        t_backpressure();
        t_drop_long();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog: actual hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule